// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. Each counter is picked by two things: a few low instruction-address bits, and a shift register that holds the outcomes of the most recent branches. A given branch address therefore owns one counter for every possible pattern of recent outcomes, not one counter overall. The fetch side presents a PC and reads the guess back combinationally in the same cycle. The execute side reports each resolved branch on the update port. That report trains the selected counter and pushes the outcome into the history register.

Each counter is a small state machine with four named states:

| State | Code | Meaning |
|-------|------|---------|
| `CTR_SNT` | 00 | strongly not-taken |
| `CTR_WNT` | 01 | weakly not-taken |
| `CTR_WT` | 10 | weakly taken |
| `CTR_ST` | 11 | strongly taken |

A taken outcome moves the counter one step along `CTR_SNT`→`CTR_WNT`→`CTR_WT`→`CTR_ST`, and `CTR_ST` stays at `CTR_ST`. A not-taken outcome moves it one step the other way, and `CTR_SNT` stays at `CTR_SNT`. The guess is the upper bit of the code.

The table index is {history, PC[5:2]} with the default parameters: 2 history bits and 4 address bits, giving 64 entries.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset every counter is in `CTR_WNT` (01), so every PC predicts not-taken, and the history register is zero.
- R2: `pred_taken` is the upper bit of the counter at index {history, pred_pc[5:2]}. It is valid combinationally in the cycle the PC is presented.
- R3: PC bits [1:0] and bits above bit 5 have no effect on which counter is selected.
- R4: An update with `upd_taken`=1 moves the selected counter up one state, and a counter in `CTR_ST` (11) stays there.
- R5: An update with `upd_taken`=0 moves the selected counter down one state, and a counter in `CTR_SNT` (00) stays there.
- R6: A counter in a strong state changes its prediction only after two consecutive opposite outcomes.
- R7: On an update, the counter is chosen with the history as it stood before that update. The history then shifts left by one, and the outcome enters at bit 0 (1 = taken).
- R8: For the same PC, different history values select different counters.
- R9: When predict and update hit the same entry in one cycle, `pred_taken` shows the value from before that update.
- R10: While `upd_valid` is low, `upd_taken` and `upd_pc` change neither the counters nor the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| pred_pc | input | 32 | address of the branch being predicted |
| pred_taken | output | 1 | predicted direction, 1 = taken |
| upd_valid | input | 1 | a resolved branch is reported this cycle |
| upd_pc | input | 32 | address of the resolved branch |
| upd_taken | input | 1 | actual outcome, 1 = taken |

## Verification
A prediction read and a counter update can fall in the same cycle and target the same entry. The history register also advances in that same cycle, so the next lookup for the same PC may already land on a different counter.

The bench provokes the collision in directed runs, presenting one PC on both ports, and also lets it occur at random through a narrow address range. A reference model advances only after the clock edge. This lets the bench judge each collision against the pre-update counter, and then check that the following lookup uses the shifted history.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_RESET = CTR_WNT;

endpackage

// File: rtl/bp_index.sv
module bp_index #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 2,
    parameter int ADDR_W = 4,
    localparam int IDX_W = HIST_W + ADDR_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    logic unused_pc_bits;

    // word-aligned fetch: bits [1:0] carry no information
    assign idx            = {hist, pc[ADDR_W+1:2]};
    assign unused_pc_bits = ^{pc[PC_W-1:ADDR_W+2], pc[1:0]};
endmodule

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= bit_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
            end
        end
    endgenerate

    assign hist = hist_q;
endmodule

// File: rtl/bp_sat_counter.sv
module bp_sat_counter
    import bp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       train_en,
    input  logic       taken,
    output logic [1:0] state,
    output logic       guess
);
    ctr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTR_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (train_en) begin
            unique case (state_q)
                CTR_SNT: state_d = taken ? CTR_WNT : CTR_SNT;
                CTR_WNT: state_d = taken ? CTR_WT  : CTR_SNT;
                CTR_WT:  state_d = taken ? CTR_ST  : CTR_WNT;
                CTR_ST:  state_d = taken ? CTR_ST  : CTR_WT;
                default: state_d = CTR_RESET;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            CTR_SNT, CTR_WNT: guess = 1'b0;
            CTR_WT,  CTR_ST:  guess = 1'b1;
            default:          guess = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
    parameter int IDX_W    = 6,
    localparam int DEPTH   = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_taken,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_taken,
    output logic [1:0]         wr_state,
    output logic [2*DEPTH-1:0] ctr_flat
);
    logic [DEPTH-1:0] guess_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        bp_sat_counter u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .train_en (wr_en && (wr_idx == IDX_W'(i))),
            .taken    (wr_taken),
            .state    (ctr_flat[2*i +: 2]),
            .guess    (guess_vec[i])
        );
    end

    // reads see registered state, so same-cycle update is not visible
    assign rd_taken = guess_vec[rd_idx];
    assign wr_state = ctr_flat[2*wr_idx +: 2];
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 2,
    parameter int ADDR_W = 4,
    localparam int IDX_W = HIST_W + ADDR_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    logic [HIST_W-1:0]  hist_q;
    logic [IDX_W-1:0]   pred_idx, upd_idx;
    logic [1:0]         upd_ctr;
    logic [2*DEPTH-1:0] ctr_flat;

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist     (hist_q)
    );

    bp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_pidx (
        .pc   (pred_pc),
        .hist (hist_q),
        .idx  (pred_idx)
    );

    bp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_uidx (
        .pc   (upd_pc),
        .hist (hist_q),
        .idx  (upd_idx)
    );

    bp_counter_table #(.IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .wr_state (upd_ctr),
        .ctr_flat (ctr_flat)
    );
endmodule

// File: rtl/corr_branch_predictor_chk.sv
module corr_branch_predictor_chk #(
    parameter int HIST_W = 2,
    parameter int IDX_W  = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid,
    input logic               upd_taken,
    input logic               pred_taken,
    input logic [HIST_W-1:0]  hist_q,
    input logic [IDX_W-1:0]   upd_idx,
    input logic [1:0]         upd_ctr,
    input logic [2*DEPTH-1:0] ctr_flat
);
    // R1: first cycle out of reset
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (hist_q == '0 && !pred_taken));

    // R4
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_ctr != 2'b11) |=>
        ctr_flat[2*$past(upd_idx) +: 2] == $past(upd_ctr) + 2'd1);

    // R4 saturation
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_ctr == 2'b11) |=>
        ctr_flat[2*$past(upd_idx) +: 2] == 2'b11);

    // R5
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_ctr != 2'b00) |=>
        ctr_flat[2*$past(upd_idx) +: 2] == $past(upd_ctr) - 2'd1);

    // R5 saturation
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_ctr == 2'b00) |=>
        ctr_flat[2*$past(upd_idx) +: 2] == 2'b00);

    // R7
    a_r7_hist_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> hist_q[0] == $past(upd_taken));

    // R10
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist_q));

    // R10
    a_r10_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ctr_flat));
endmodule

bind corr_branch_predictor corr_branch_predictor_chk #(
    .HIST_W (HIST_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .pred_taken (pred_taken),
    .hist_q     (hist_q),
    .upd_idx    (upd_idx),
    .upd_ctr    (upd_ctr),
    .ctr_flat   (ctr_flat)
);

// File: tb/tb_corr_branch_predictor.sv
module tb_corr_branch_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 2;
    localparam int AW = 4;
    localparam int NENT = 1 << (HW + AW);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int mdl [NENT];
    int mhist = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    corr_branch_predictor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    function automatic int midx(input logic [31:0] pc);
        return (mhist << AW) | int'(pc[AW+1:2]);
    endfunction

    function automatic logic mpred(input logic [31:0] pc);
        return mdl[midx(pc)] >= 2;
    endfunction

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // one cycle: drive at negedge, compare, clock, advance model
    task automatic step(input logic [31:0] ppc, input logic v,
                        input logic [31:0] upc, input logic t, input string tag);
        logic exp;
        pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t;
        #1;
        exp = mpred(ppc);
        n_chk++;
        if (pred_taken !== exp) begin
            n_bad++;
            $display("FAIL %s: pc=%h pred_taken=%0b expected %0b", tag, ppc, pred_taken, exp);
        end
        @(posedge clk);
        if (v && rst_n) begin
            int k;
            k = midx(upc);
            if (t) begin if (mdl[k] < 3) mdl[k]++; end
            else   begin if (mdl[k] > 0) mdl[k]--; end
            mhist = ((mhist << 1) | int'(t)) & ((1 << HW) - 1);
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            report();
        end
    end

    initial begin
        logic [31:0] pa, pb;
        logic [31:0] rp;
        for (int i = 0; i < NENT; i++) mdl[i] = 1;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        // reset held: updates must not matter
        step(32'h100, 1'b1, 32'h100, 1'b1, "R1 during reset");
        step(32'h100, 1'b1, 32'h100, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++)
            step(32'h4000 + 32'(i*4), 1'b0, '0, 1'b0, "R1 reset state");

        // R4/R6: train one branch taken; history saturates to 11
        pa = 32'h0000_0040;
        for (int i = 0; i < 6; i++) step(pa, 1'b1, pa, 1'b1, "R4 R9 train up");
        step(pa, 1'b0, '0, 1'b0, "R4 saturated taken");
        // R3: aliasing through ignored bits
        step(pa | 32'h3, 1'b0, '0, 1'b0, "R3 low bits ignored");
        step(pa | 32'hFF00_0000, 1'b0, '0, 1'b0, "R3 high bits ignored");
        // R6: one not-taken, history now 10 -> different counter
        step(pa, 1'b1, pa, 1'b0, "R6 first miss");
        step(pa, 1'b1, pa, 1'b1, "R8 other history");
        step(pa, 1'b0, '0, 1'b0, "R6 R8 lookup");
        // R5: drive not-taken repeatedly
        for (int i = 0; i < 7; i++) step(pa, 1'b1, pa, 1'b0, "R5 R6 train down");
        step(pa, 1'b0, '0, 1'b0, "R5 saturated not-taken");
        // R10: update inputs toggled with valid low
        for (int i = 0; i < 5; i++) step(pa, 1'b0, pa, 1'b1, "R10 valid low");
        // R9: collision on different PC with predict == update
        pb = 32'h0000_0008;
        for (int i = 0; i < 4; i++) step(pb, 1'b1, pb, 1'b1, "R9 same entry");
        // R7: history pattern alternation
        for (int i = 0; i < 8; i++) step(pb, 1'b1, pa, 1'(i & 1), "R7 history shift");

        // constrained random: narrow address range so collisions recur
        for (int i = 0; i < 4000; i++) begin
            rp = {$urandom} & 32'h0000_007F;
            step(({$urandom} & 32'h0000_007F) | (32'($urandom_range(0,1)) << 28),
                 1'($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 2) == 0) ? pred_pc : rp,
                 1'($urandom_range(0, 4) < 3),
                 "R2 R4 R5 R7 random");
        end

        done = 1;
        report();
    end
endmodule